// File: doc/BRIEF.md
# Disk Change Latch

This block keeps one "media may have changed" flag for each of four drives. A pulse from a drive's door sensor, on opening or on closing, sets that drive's flag. The flag is read back as the top bit of an 8-bit input-register value. That bit shows the flag of the drive picked by the select field, and only while that drive's motor bit is on.

The flag clears only after a head-positioning operation on that drive succeeds and moves the heads to a different cylinder. Every kind of positioning reports through the same completion port: explicit seeks, relative seeks, implied seeks and recalibrates. Each report gives the drive, the target cylinder, the cylinder the heads were on, and a success bit. The following cases all leave the flag set:
- a seek to the cylinder the heads already occupy;
- a recalibrate issued at cylinder 0;
- a failed operation.

A failed operation also raises a no-media indication for that drive.

When the select field changes, the read value keeps showing the previously displayed bit for a programmable number of cycles. After that window the newly selected drive's flag appears.

Top module: `disk_change_latch`

## Requirements
- R1: After reset, every flag and every no-media bit is 0 and `dir_rdata` reads 0x00.
- R2: A 1 on `door_evt[i]` at a clock edge sets the flag of drive i from the next cycle on. Other drives' flags are left as they were.
- R3: A report on `done_vld` with `done_ok`=1 and `done_tgt` different from `done_cur` clears the flag of drive `done_drv` only.
- R4: A report with `done_tgt` equal to `done_cur` leaves the flag unchanged, whether `done_ok` is 1 or 0. This covers a seek to the present cylinder and a recalibrate at cylinder 0 (target 0, present 0).
- R5: A report with `done_ok`=0 leaves the flag set and sets `no_media[done_drv]`. A report with `done_ok`=1 clears `no_media[done_drv]`.
- R6: If a door event and a clearing report for the same drive arrive in the same cycle, the flag ends up set.
- R7: Outside a settle window, `dir_rdata[7]` equals the flag of drive `drv_sel` when `motor_on[drv_sel]`=1, and reads 0 when that motor bit is 0.
- R8: `dir_rdata[6:0]` always reads 0.
- R9: When `drv_sel` changes and `settle_cycles`=N>0, `dir_rdata[7]` holds its last displayed value for N sampled cycles, counting the cycle of the change. A further change during the window restarts it. With N=0 the new drive shows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, the only thing that clears flags wholesale |
| door_evt | input | DRIVES | One-cycle door open/close pulse per drive |
| drv_sel | input | SEL_W | Selected drive |
| motor_on | input | DRIVES | Motor bit per drive |
| settle_cycles | input | CNT_W | Length of the stale window after a select change |
| done_vld | input | 1 | Positioning completion report valid |
| done_drv | input | SEL_W | Drive that completed |
| done_tgt | input | CYL_W | Target cylinder of the operation |
| done_cur | input | CYL_W | Cylinder the heads were on beforehand |
| done_ok | input | 1 | Operation succeeded |
| dir_rdata | output | 8 | Input-register read value, flag in bit 7 |
| no_media | output | DRIVES | Per-drive no-media indication |

## Verification
The clearing rule is tried with four kinds of completion report:
- a move to a new cylinder, which clears;
- a seek to the same cylinder;
- a recalibrate at cylinder 0;
- a failed move.

These tell a rule that looks at head movement apart from one that clears on any success. Reports aimed at another drive and a door pulse landing together with a clearing report check per-drive isolation and set priority. Reads are taken with the motor bit off, on drive masks with alternating bits, and across select changes with zero and nonzero settle lengths. Together they separate gating by motor, gating by select and the stale window.

// File: rtl/disk_change_latch.sv
module disk_change_latch #(
  parameter int DRIVES = 4,
  parameter int CYL_W  = 8,
  parameter int CNT_W  = 8,
  localparam int SEL_W = $clog2(DRIVES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DRIVES-1:0] door_evt,
  input  logic [SEL_W-1:0]  drv_sel,
  input  logic [DRIVES-1:0] motor_on,
  input  logic [CNT_W-1:0]  settle_cycles,
  input  logic              done_vld,
  input  logic [SEL_W-1:0]  done_drv,
  input  logic [CYL_W-1:0]  done_tgt,
  input  logic [CYL_W-1:0]  done_cur,
  input  logic              done_ok,
  output logic [7:0]        dir_rdata,
  output logic [DRIVES-1:0] no_media
);

  logic [DRIVES-1:0] flag_q, nm_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              stale_q;

  wire moved    = done_tgt != done_cur;
  wire live_bit = flag_q[drv_sel] & motor_on[drv_sel];
  wire chg      = drv_sel != sel_q;
  wire hold     = (chg && settle_cycles != '0) || cnt_q != '0;
  wire shown    = hold ? stale_q : live_bit;

  assign dir_rdata = {shown, 7'b0};
  assign no_media  = nm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      nm_q   <= '0;
    end else begin
      for (int i = 0; i < DRIVES; i++) begin
        if (door_evt[i])
          flag_q[i] <= 1'b1;
        else if (done_vld && done_drv == SEL_W'(i) && done_ok && moved)
          flag_q[i] <= 1'b0;
        if (done_vld && done_drv == SEL_W'(i))
          nm_q[i] <= !done_ok;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      cnt_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      sel_q   <= drv_sel;
      stale_q <= shown;
      if (chg)
        cnt_q <= (settle_cycles == '0) ? '0 : settle_cycles - 1'b1;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/disk_change_latch_chk.sv
module disk_change_latch_chk #(
  parameter int DRIVES = 4,
  parameter int CYL_W  = 8,
  parameter int CNT_W  = 8,
  localparam int SEL_W = $clog2(DRIVES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DRIVES-1:0] door_evt,
  input logic [SEL_W-1:0]  drv_sel,
  input logic [DRIVES-1:0] motor_on,
  input logic              done_vld,
  input logic [SEL_W-1:0]  done_drv,
  input logic [CYL_W-1:0]  done_tgt,
  input logic [CYL_W-1:0]  done_cur,
  input logic              done_ok,
  input logic [7:0]        dir_rdata,
  input logic [DRIVES-1:0] no_media,
  input logic [DRIVES-1:0] flag_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic [CNT_W-1:0]  cnt_q
);

  p_door_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    door_evt != '0 |=> (flag_q & $past(door_evt)) == $past(door_evt));

  p_rise_only_by_door_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q)) & ~$past(door_evt)) == '0);

  p_move_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && done_ok && done_tgt != done_cur && !door_evt[done_drv]
    |=> !flag_q[$past(done_drv)]);

  p_same_cyl_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && done_tgt == done_cur && flag_q[done_drv]
    |=> flag_q[$past(done_drv)]);

  p_fail_no_media_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && !done_ok |=> no_media[$past(done_drv)]);

  p_motor_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 && drv_sel == sel_q && !motor_on[drv_sel] |-> !dir_rdata[7]);

  p_settle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0 |-> $stable(dir_rdata));

endmodule

bind disk_change_latch disk_change_latch_chk #(
  .DRIVES(DRIVES), .CYL_W(CYL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .door_evt(door_evt), .drv_sel(drv_sel),
  .motor_on(motor_on), .done_vld(done_vld), .done_drv(done_drv),
  .done_tgt(done_tgt), .done_cur(done_cur), .done_ok(done_ok),
  .dir_rdata(dir_rdata), .no_media(no_media), .flag_q(flag_q),
  .sel_q(sel_q), .cnt_q(cnt_q)
);

// File: tb/sim_disk_change_latch.sv
module sim_disk_change_latch;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] door_evt = 0;
  logic [1:0] drv_sel = 0;
  logic [3:0] motor_on = 4'hF;
  logic [7:0] settle_cycles = 0;
  logic       done_vld = 0;
  logic [1:0] done_drv = 0;
  logic [7:0] done_tgt = 0, done_cur = 0;
  logic       done_ok = 0;
  logic [7:0] dir_rdata;
  logic [3:0] no_media;

  int tests = 0, fails = 0;
  bit finished = 0;

  typedef struct { string tag; logic [7:0] dir; logic [3:0] nm; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  disk_change_latch u0 (
    .clk(clk), .rst_n(rst_n), .door_evt(door_evt), .drv_sel(drv_sel),
    .motor_on(motor_on), .settle_cycles(settle_cycles), .done_vld(done_vld),
    .done_drv(done_drv), .done_tgt(done_tgt), .done_cur(done_cur),
    .done_ok(done_ok), .dir_rdata(dir_rdata), .no_media(no_media)
  );

  // monitor: pops expectations and compares 1 ns after the falling edge
  initial forever begin
    @(negedge clk); #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (dir_rdata !== e.dir || no_media !== e.nm) begin
        fails++;
        $display("FAIL %s: dir=%h exp %h no_media=%b exp %b",
                 e.tag, dir_rdata, e.dir, no_media, e.nm);
      end
    end
  end

  task automatic expect_now(string tag, logic [7:0] d, logic [3:0] n);
    exp_t e;
    e.tag = tag; e.dir = d; e.nm = n;
    q.push_back(e);
  endtask

  task automatic door(logic [3:0] m);
    @(negedge clk); door_evt = m;
    @(negedge clk); door_evt = 0;
  endtask

  task automatic report(logic [1:0] d, logic [7:0] t, logic [7:0] c, logic ok,
                        logic [3:0] dm = 0);
    @(negedge clk);
    done_vld = 1; done_drv = d; done_tgt = t; done_cur = c; done_ok = ok;
    door_evt = dm;
    @(negedge clk); done_vld = 0; door_evt = 0;
  endtask

  task automatic select(logic [1:0] d);
    @(negedge clk); drv_sel = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_now("R1 reset state", 8'h00, 4'b0000);

    door(4'b0001);
    expect_now("R2 door sets drive0", 8'h80, 4'b0000);
    select(1);
    expect_now("R2 other drive untouched", 8'h00, 4'b0000);
    select(0);
    expect_now("R7 selected drive0 shows flag", 8'h80, 4'b0000);

    report(0, 8'd5, 8'd5, 1);
    expect_now("R4 seek to same cylinder keeps flag", 8'h80, 4'b0000);
    report(0, 8'd0, 8'd0, 1);
    expect_now("R4 recalibrate at cylinder 0 keeps flag", 8'h80, 4'b0000);
    report(0, 8'd3, 8'd5, 0);
    expect_now("R5 failed move keeps flag, no-media set", 8'h80, 4'b0001);

    @(negedge clk); motor_on = 4'b1110;
    expect_now("R7 motor off hides flag", 8'h00, 4'b0001);
    @(negedge clk); motor_on = 4'hF;
    expect_now("R7 motor on shows flag", 8'h80, 4'b0001);

    report(1, 8'd9, 8'd2, 1);
    expect_now("R3 clear of drive1 leaves drive0", 8'h80, 4'b0001);
    report(0, 8'd7, 8'd5, 1);
    expect_now("R3 move clears flag, R5 success clears no-media", 8'h00, 4'b0000);

    report(0, 8'd4, 8'd7, 1, 4'b0001);
    expect_now("R6 door wins over clearing report", 8'h80, 4'b0000);

    door(4'b1010);
    select(3);
    expect_now("R2 mask 1010 drive3 set", 8'h80, 4'b0000);
    select(2);
    expect_now("R8 drive2 clear, low bits zero", 8'h00, 4'b0000);

    @(negedge clk); settle_cycles = 3; drv_sel = 3;
    expect_now("R9 stale on change cycle", 8'h00, 4'b0000);
    @(negedge clk);
    expect_now("R9 stale second cycle", 8'h00, 4'b0000);
    @(negedge clk);
    expect_now("R9 stale third cycle", 8'h00, 4'b0000);
    @(negedge clk);
    expect_now("R9 new drive after settle", 8'h80, 4'b0000);

    @(negedge clk); drv_sel = 2;
    expect_now("R9 stale restarts", 8'h80, 4'b0000);
    @(negedge clk); drv_sel = 1;
    expect_now("R9 re-change holds stale", 8'h80, 4'b0000);
    @(negedge clk);
    expect_now("R9 still stale", 8'h80, 4'b0000);
    @(negedge clk);
    expect_now("R9 still stale last", 8'h80, 4'b0000);
    @(negedge clk);
    expect_now("R9 drive1 live after restart", 8'h80, 4'b0000);

    report(1, 8'd1, 8'd0, 1);
    expect_now("R3 drive1 cleared", 8'h00, 4'b0000);
    report(2, 8'd1, 8'd3, 0);
    expect_now("R5 no-media on drive2", 8'h00, 4'b0100);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule